// File: doc/BRIEF.md
# Priority maskable interrupt controller

This block arbitrates nineteen maskable interrupt sources for a CPU. Each source owns a small control byte. The byte holds a two-bit priority level, a mask bit and a pending-request bit. It also holds two bits that select how the request is serviced: as a context switch, or handed over to the macro-service engine. A one-cycle event pulse on a source's request line sets its pending bit. The pending bit stays set until the CPU accepts that source or software clears it.

Every cycle in which no request is offered, the block looks at all sources that are pending and not masked. It takes the numerically smallest priority level among them. If several sources share that level, the lowest source index wins. The winner is registered and offered to the CPU with a valid flag, a five-bit source index and a two-bit service type. It stays there unchanged until the CPU returns an acknowledge pulse, and that pulse clears the winner's pending bit. A per-source "macro counter reached zero" input clears that source's macro-service bit. A byte-wide port, addressed by source index and written under a per-bit write enable, gives software access to every flag.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every source reads priority 3, mask 1, pending 0, context-switch 0 and macro 0 (byte 0x07), and `cpu_valid` is 0.
- R2: A one-cycle pulse on `irq_evt[i]` sets pending bit i at the next clock edge. A register write changes only the bits whose `reg_wmask` bit is 1.
- R3: A masked source never becomes the offered winner, even while its pending bit is set. Acknowledging a source leaves its mask bit unchanged.
- R4: Among pending, unmasked sources, the one with the numerically smallest priority level is offered.
- R5: Among pending, unmasked sources that share the best level, the lowest source index is offered.
- R6: An acknowledge while `cpu_valid` is 1 clears the pending bit of the offered source only, and `cpu_valid` is 0 in the following cycle.
- R7: While `cpu_valid` is 1 and no acknowledge arrives, `cpu_idx` and `cpu_type` hold their values. This is true even if a better request becomes pending.
- R8: `cpu_type` is 2 when the winner's macro bit is set. Otherwise it is 1 when the winner's context-switch bit is set. Otherwise it is 0 (vectored).
- R9: A pulse on `ms_zero[i]` clears the macro bit of source i only.
- R10: When an event on source i and a software clear of pending bit i fall in the same cycle, the pending bit ends up set.
- R11: The control byte layout is: bits 1:0 priority, bit 2 mask, bit 3 pending, bit 4 context-switch, bit 5 macro, bits 7:6 always read 0.
- R12: Writes to addresses of 19 and above have no effect, and reads of those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_evt | input | 19 | Per-source request event pulses |
| ms_zero | input | 19 | Per-source macro-counter-reached-zero pulses |
| reg_addr | input | 5 | Source index of the control byte to access |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_wmask | input | 8 | Per-bit write enable |
| reg_rdata | output | 8 | Control byte of the addressed source |
| cpu_valid | output | 1 | A request is offered to the CPU |
| cpu_idx | output | 5 | Index of the offered source |
| cpu_type | output | 2 | Service type: 0 vectored, 1 context switch, 2 macro |
| cpu_ack | input | 1 | CPU accepts the offered request |

## Verification
The bench targets these cases:
- **Simultaneous requests at different levels.** A design that compared indices before levels would offer the lower index first.
- **Ties within one level.** A reversed default order would offer the higher index.
- **A better request arriving while one is offered.** A controller that re-arbitrated every cycle would change `cpu_idx` before the acknowledge.
- **Same-cycle event and software clear.** This shows whether the hardware set wins. Getting it wrong would silently drop a request.
- **A masked pending source.** A design that ignored the mask would offer it.
- **Macro completion on one source.** A decode slip would also clear a neighbouring source's macro bit.
- **Out-of-range addresses.** A design that aliased them would corrupt a real source.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int PRIO_W = 2;
    localparam int CTRL_W = 8;
    // control byte field positions
    localparam int F_PRIO  = 0;
    localparam int F_MASK  = 2;
    localparam int F_REQ   = 3;
    localparam int F_CTX   = 4;
    localparam int F_MS    = 5;

    typedef enum logic [1:0] {
        SVC_VECT  = 2'd0,
        SVC_CTX   = 2'd1,
        SVC_MACRO = 2'd2
    } svc_e;
endpackage

// File: rtl/irq_src_regs.sv
module irq_src_regs
    import irq_pkg::*;
#(
    parameter int NSRC = 19,
    parameter int AW   = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NSRC-1:0]               irq_evt,
    input  logic [NSRC-1:0]               ms_zero,
    input  logic [NSRC-1:0]               ack_clr,
    input  logic [AW-1:0]                 reg_addr,
    input  logic                          reg_we,
    input  logic [CTRL_W-1:0]             reg_wdata,
    input  logic [CTRL_W-1:0]             reg_wmask,
    output logic [CTRL_W-1:0]             reg_rdata,
    output logic [NSRC-1:0][PRIO_W-1:0]   prio,
    output logic [NSRC-1:0]               mask,
    output logic [NSRC-1:0]               req,
    output logic [NSRC-1:0]               ctx,
    output logic [NSRC-1:0]               ms
);
    typedef struct packed {
        logic [NSRC-1:0][PRIO_W-1:0] prio;
        logic [NSRC-1:0]             mask;
        logic [NSRC-1:0]             req;
        logic [NSRC-1:0]             ctx;
        logic [NSRC-1:0]             ms;
    } regs_t;

    regs_t r_d, r_q;
    logic [NSRC-1:0] sel;

    function automatic logic merge(input logic old, input logic nw, input logic en);
        return en ? nw : old;
    endfunction

    // address decode, one select per source
    for (genvar g = 0; g < NSRC; g++) begin : g_sel
        assign sel[g] = reg_we && (reg_addr == AW'(g));
    end

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < NSRC; i++) begin
            if (sel[i]) begin
                for (int b = 0; b < PRIO_W; b++) begin
                    r_d.prio[i][b] = merge(r_q.prio[i][b], reg_wdata[F_PRIO+b], reg_wmask[F_PRIO+b]);
                end
                r_d.mask[i] = merge(r_q.mask[i], reg_wdata[F_MASK], reg_wmask[F_MASK]);
                r_d.req[i]  = merge(r_q.req[i],  reg_wdata[F_REQ],  reg_wmask[F_REQ]);
                r_d.ctx[i]  = merge(r_q.ctx[i],  reg_wdata[F_CTX],  reg_wmask[F_CTX]);
                r_d.ms[i]   = merge(r_q.ms[i],   reg_wdata[F_MS],   reg_wmask[F_MS]);
            end
            if (ack_clr[i]) r_d.req[i] = 1'b0;
            if (irq_evt[i]) r_d.req[i] = 1'b1;   // hardware set wins
            if (ms_zero[i]) r_d.ms[i]  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.prio <= '1;
            r_q.mask <= '1;
            r_q.req  <= '0;
            r_q.ctx  <= '0;
            r_q.ms   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (reg_addr == AW'(i)) begin
                reg_rdata[F_PRIO +: PRIO_W] = r_q.prio[i];
                reg_rdata[F_MASK] = r_q.mask[i];
                reg_rdata[F_REQ]  = r_q.req[i];
                reg_rdata[F_CTX]  = r_q.ctx[i];
                reg_rdata[F_MS]   = r_q.ms[i];
            end
        end
    end

    assign prio = r_q.prio;
    assign mask = r_q.mask;
    assign req  = r_q.req;
    assign ctx  = r_q.ctx;
    assign ms   = r_q.ms;

    // R9
    ms_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_zero != '0) |=> ((r_q.ms & $past(ms_zero)) == '0));
    // R10
    evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_evt != '0) |=> ((r_q.req & $past(irq_evt)) == $past(irq_evt)));
    // R3
    mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_we |=> $stable(r_q.mask));
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
#(
    parameter int NSRC = 19,
    parameter int AW   = 5
) (
    input  logic [NSRC-1:0][PRIO_W-1:0] prio,
    input  logic [NSRC-1:0]             mask,
    input  logic [NSRC-1:0]             req,
    input  logic [NSRC-1:0]             ctx,
    input  logic [NSRC-1:0]             ms,
    output logic                        any,
    output logic [AW-1:0]               win_idx,
    output svc_e                        win_type
);
    logic [NSRC-1:0]   elig;
    logic [PRIO_W-1:0] best;

    assign elig = req & ~mask;

    always_comb begin
        any     = 1'b0;
        best    = '1;
        win_idx = '0;
        // strict compare keeps the lower index on a tie
        for (int i = 0; i < NSRC; i++) begin
            if (elig[i] && (!any || prio[i] < best)) begin
                any     = 1'b1;
                best    = prio[i];
                win_idx = AW'(i);
            end
        end
        if (ms[win_idx])       win_type = SVC_MACRO;
        else if (ctx[win_idx]) win_type = SVC_CTX;
        else                   win_type = SVC_VECT;
    end

    always_comb begin
        if (any) begin
            // R3
            win_elig_chk: assert (elig[win_idx]);
            for (int j = 0; j < NSRC; j++) begin
                // R4 R5
                if (elig[j]) begin
                    best_pick_chk: assert (prio[j] > prio[win_idx] ||
                                           (prio[j] == prio[win_idx] && AW'(j) >= win_idx));
                end
            end
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int NSRC = 19,
    parameter int AW   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_evt,
    input  logic [NSRC-1:0]   ms_zero,
    input  logic [AW-1:0]     reg_addr,
    input  logic              reg_we,
    input  logic [7:0]        reg_wdata,
    input  logic [7:0]        reg_wmask,
    output logic [7:0]        reg_rdata,
    output logic              cpu_valid,
    output logic [AW-1:0]     cpu_idx,
    output logic [1:0]        cpu_type,
    input  logic              cpu_ack
);
    typedef struct packed {
        logic          valid;
        logic [AW-1:0] idx;
        svc_e          svc;
    } offer_t;

    offer_t o_d, o_q;

    logic [NSRC-1:0][PRIO_W-1:0] prio;
    logic [NSRC-1:0] mask, req, ctx, ms, ack_clr;
    logic            any;
    logic [AW-1:0]   win_idx;
    svc_e            win_type;

    irq_src_regs #(.NSRC(NSRC), .AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .ms_zero(ms_zero),
        .ack_clr(ack_clr), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .reg_rdata(reg_rdata),
        .prio(prio), .mask(mask), .req(req), .ctx(ctx), .ms(ms)
    );

    irq_arb #(.NSRC(NSRC), .AW(AW)) u_arb (
        .prio(prio), .mask(mask), .req(req), .ctx(ctx), .ms(ms),
        .any(any), .win_idx(win_idx), .win_type(win_type)
    );

    for (genvar g = 0; g < NSRC; g++) begin : g_ack
        assign ack_clr[g] = o_q.valid && cpu_ack && (o_q.idx == AW'(g));
    end

    always_comb begin
        o_d = o_q;
        if (o_q.valid) begin
            if (cpu_ack) o_d.valid = 1'b0;
        end else if (any) begin
            o_d.valid = 1'b1;
            o_d.idx   = win_idx;
            o_d.svc   = win_type;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_q <= '{valid: 1'b0, idx: '0, svc: SVC_VECT};
        end else begin
            o_q <= o_d;
        end
    end

    assign cpu_valid = o_q.valid;
    assign cpu_idx   = o_q.idx;
    assign cpu_type  = o_q.svc;

    // R7
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && !cpu_ack) |=> (cpu_valid && $stable(cpu_idx) && $stable(cpu_type)));
    // R6
    ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ack) |=> !cpu_valid);
    // R6
    ack_req_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_valid && cpu_ack && !irq_evt[cpu_idx]) |=> !req[$past(cpu_idx)]);
    // R8
    type_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_valid |-> (cpu_type != 2'd3 && int'(cpu_idx) < NSRC));
endmodule

// File: tb/tb_irq_ctrl.sv
module tb_irq_ctrl;
    localparam int NSRC = 19;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NSRC-1:0] irq_evt = '0;
    logic [NSRC-1:0] ms_zero = '0;
    logic [4:0]      reg_addr = '0;
    logic            reg_we = 1'b0;
    logic [7:0]      reg_wdata = '0;
    logic [7:0]      reg_wmask = '0;
    logic [7:0]      reg_rdata;
    logic            cpu_valid;
    logic [4:0]      cpu_idx;
    logic [1:0]      cpu_type;
    logic            cpu_ack = 1'b0;

    int errors = 0;
    int checks = 0;

    always #4 clk = ~clk;   // 125 MHz

    irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .irq_evt(irq_evt), .ms_zero(ms_zero),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_wmask(reg_wmask), .reg_rdata(reg_rdata), .cpu_valid(cpu_valid),
        .cpu_idx(cpu_idx), .cpu_type(cpu_type), .cpu_ack(cpu_ack)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [7:0] d, input logic [7:0] m);
        reg_addr = 5'(a); reg_wdata = d; reg_wmask = m; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string tag);
        reg_addr = 5'(a);
        #1;
        chk(reg_rdata == 8'(exp), tag, int'(reg_rdata), exp);
    endtask

    task automatic pulse(input logic [NSRC-1:0] v);
        irq_evt = v;
        @(negedge clk);
        irq_evt = '0;
    endtask

    task automatic ack();
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
    endtask

    task automatic offer_chk(input logic v, input int idx, input int typ, input string tag);
        chk(cpu_valid == v, {tag, " valid"}, int'(cpu_valid), int'(v));
        if (v) begin
            chk(cpu_idx == 5'(idx), {tag, " idx"}, int'(cpu_idx), idx);
            chk(cpu_type == 2'(typ), {tag, " type"}, int'(cpu_type), typ);
        end
    endtask

    task automatic t_reset();
        for (int i = 0; i < NSRC; i++) rd_chk(i, 8'h07, "R1 reset byte");
        offer_chk(1'b0, 0, 0, "R1 reset offer");
    endtask

    task automatic t_bitwrite();
        wr(4, 8'h00, 8'h04);
        rd_chk(4, 8'h03, "R2 mask bit only");
        wr(4, 8'hFC, 8'h03);
        rd_chk(4, 8'h00, "R2 R11 prio bits only");
    endtask

    task automatic t_event();
        pulse(NSRC'(1) << 4);
        rd_chk(4, 8'h08, "R2 event sets pending");
        @(negedge clk);
        offer_chk(1'b1, 4, 0, "R8 vectored offer");
        ack();
        offer_chk(1'b0, 0, 0, "R6 valid drops");
        rd_chk(4, 8'h00, "R6 R3 pending clear mask kept");
    endtask

    task automatic t_mask();
        pulse(NSRC'(1) << 7);
        repeat (3) @(negedge clk);
        offer_chk(1'b0, 0, 0, "R3 masked not offered");
        rd_chk(7, 8'h0F, "R3 masked pending held");
        wr(7, 8'h00, 8'h08);
        rd_chk(7, 8'h07, "R2 sw clears pending");
    endtask

    task automatic t_prio();
        wr(2, 8'h00, 8'h04);
        wr(10, 8'h01, 8'h07);
        pulse((NSRC'(1) << 2) | (NSRC'(1) << 10));
        @(negedge clk);
        offer_chk(1'b1, 10, 0, "R4 better level first");
        ack();
        @(negedge clk);
        offer_chk(1'b1, 2, 0, "R4 remaining source");
        ack();
    endtask

    task automatic t_tie();
        wr(5, 8'h02, 8'h07);
        wr(12, 8'h02, 8'h07);
        pulse((NSRC'(1) << 5) | (NSRC'(1) << 12));
        @(negedge clk);
        offer_chk(1'b1, 5, 0, "R5 lower index first");
        ack();
        rd_chk(12, 8'h0A, "R6 other pending kept");
        @(negedge clk);
        offer_chk(1'b1, 12, 0, "R5 higher index next");
        ack();
    endtask

    task automatic t_hold();
        pulse(NSRC'(1) << 12);
        @(negedge clk);
        offer_chk(1'b1, 12, 0, "R7 offer loaded");
        pulse(NSRC'(1) << 4);
        repeat (2) @(negedge clk);
        offer_chk(1'b1, 12, 0, "R7 offer held");
        ack();
        @(negedge clk);
        offer_chk(1'b1, 4, 0, "R4 better waiting source");
        ack();
    endtask

    task automatic t_type();
        wr(15, 8'h10, 8'h17);
        pulse(NSRC'(1) << 15);
        @(negedge clk);
        offer_chk(1'b1, 15, 1, "R8 context switch");
        ack();
        wr(16, 8'h30, 8'h37);
        pulse(NSRC'(1) << 16);
        @(negedge clk);
        offer_chk(1'b1, 16, 2, "R8 macro over context");
        ack();
        wr(15, 8'h20, 8'h20);
        rd_chk(15, 8'h30, "R11 macro bit position");
        ms_zero = NSRC'(1) << 16;
        @(negedge clk);
        ms_zero = '0;
        rd_chk(16, 8'h10, "R9 macro bit cleared");
        rd_chk(15, 8'h30, "R9 neighbour macro kept");
    endtask

    task automatic t_race();
        irq_evt = NSRC'(1) << 4;
        reg_addr = 5'd4; reg_wdata = 8'h00; reg_wmask = 8'h08; reg_we = 1'b1;
        @(negedge clk);
        irq_evt = '0; reg_we = 1'b0;
        rd_chk(4, 8'h08, "R10 event beats sw clear");
        @(negedge clk);
        offer_chk(1'b1, 4, 0, "R10 request survives");
        ack();
    endtask

    task automatic t_range();
        wr(20, 8'hFF, 8'hFF);
        rd_chk(20, 8'h00, "R12 out of range reads zero");
        rd_chk(18, 8'h07, "R12 last source untouched");
        rd_chk(0, 8'h07, "R12 first source untouched");
        repeat (2) @(negedge clk);
        offer_chk(1'b0, 0, 0, "R12 no offer");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bitwrite();
        t_event();
        t_mask();
        t_prio();
        t_tie();
        t_hold();
        t_type();
        t_race();
        t_range();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 100000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule